// File: doc/BRIEF.md
# Program Counter and Return Stack Unit

This block decides where a small 4-bit controller fetches next. It holds a 9-bit program counter and a two-entry return stack. Each time the sequencer pulses `step`, the block executes the instruction at the current address. For a long jump or a long call the sequencer also presents the second byte on `instr_ext`. Plain instructions advance the counter. Jumps, page jumps, calls, returns and the indirect jump load a new address. Addresses are split into 64-word pages, and the upper three counter bits select the page.

The reach of a jump within the page depends on where the code runs. On pages 2 and 3 every byte with the top bit set is such a jump, with a 7-bit offset. On the other pages only bytes with the two top bits set are page jumps, with a 6-bit offset. There, the `10xxxxxx` bytes are one-byte calls into page 2. A return-and-skip sets a pending skip. The next instruction is then fetched but not executed, and the counter steps over its full length.

The indirect jump forms a ROM address from the high counter bit, the accumulator and the RAM digit. It expects the ROM word on `rom_data` in the same cycle and places that word in the low eight counter bits.

Top module: `flowctl_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter becomes 0, the skip flag clears and both stack entries become 0. A return right after reset goes to address 0.
- R2: While `step` is low the counter holds. A stepped byte that is not a control transfer advances the counter by one, and address 0x1FF wraps to 0x000.
- R3: A long jump (first byte `0110000h`, h = target bit 8; second byte = target bits 7..0) loads the whole 9-bit target.
- R4: A long call (first byte `0110100h`, second byte as for R3) moves the top entry to the second entry and pushes the counter plus 2, then loads the target.
- R5: On any page other than 2 or 3, a byte `10tttttt` other than 0xBF is a page call. It pushes the counter plus 1 (top entry into second) and sets counter bits 8..6 to 010 and bits 5..0 to `tttttt`.
- R6: On pages 2 and 3 (counter bits 8..7 = 01), any byte `1ttttttt` other than 0xFF replaces counter bits 6..0 and keeps bits 8..7.
- R7: On other pages a byte `11tttttt` other than 0xFF replaces counter bits 5..0 and keeps bits 8..6. Byte 0xBF on these pages advances the counter by one.
- R8: Return (0x48) loads the counter from the top entry and moves the second entry to the top. The second entry keeps its value.
- R9: Return-and-skip (0x49) acts as R8 and sets the skip flag. The next stepped instruction is not executed: the counter advances by its length (2 for R3/R4 first bytes, else 1), the stack is untouched and the flag clears.
- R10: Indirect jump (0xFF) drives `rom_addr` = {counter bit 8, acc, ram_val} and loads counter bits 7..0 from `rom_data`, keeping bit 8.
- R11: The stack holds two entries. A third push loses the oldest, and repeated returns keep yielding the last remaining entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Execute the instruction at `fetch_addr` this cycle |
| instr | input | 8 | First instruction byte |
| instr_ext | input | 8 | Second instruction byte for long jump/call |
| acc | input | 4 | Accumulator digit |
| ram_val | input | 4 | RAM operand digit |
| rom_data | input | 8 | ROM word for the indirect jump |
| fetch_addr | output | 9 | Program counter, the next fetch address |
| skip_pending | output | 1 | Next stepped instruction will be suppressed |
| rom_addr | output | 9 | Lookup address for the indirect jump |

## Verification
The bench builds the unit with its default parameters: a 9-bit counter, 64-word pages, 4-bit digits and a two-deep stack. With these values the whole address space fits in a few hundred steps. The bench covers page-2/3 versus other-page decoding of the same byte, calls that land in page 2, the wrap at 0x1FF, and a third push that overflows the stack. With only two entries, the duplicated bottom entry shows up after two returns. A suppressed two-byte instruction shows that the step over counts both bytes.

// File: rtl/flowctl_pkg.sv
// Shared types and opcode constants for the control-transfer unit.
// Assumes 8-bit instruction bytes.
package flowctl_pkg;

    typedef enum logic [2:0] {
        XFER_SEQ   = 3'd0,
        XFER_JMP   = 3'd1,
        XFER_JSR   = 3'd2,
        XFER_JSRP  = 3'd3,
        XFER_JP    = 3'd4,
        XFER_RET   = 3'd5,
        XFER_RETSK = 3'd6,
        XFER_JID   = 3'd7
    } xfer_e;

    localparam logic [7:0] OPC_JMP_HI = 8'h60;
    localparam logic [7:0] OPC_JSR_HI = 8'h68;
    localparam logic [7:0] OPC_RET    = 8'h48;
    localparam logic [7:0] OPC_RETSK  = 8'h49;
    localparam logic [7:0] OPC_JID    = 8'hFF;
    localparam logic [7:0] OPC_LQ_IND = 8'hBF;

endpackage

// File: rtl/flowctl_decode.sv
// Classifies the first instruction byte into a transfer kind.
// The meaning of the top-bit-set bytes depends on whether the
// current page is one of the wide-jump pages (2 or 3).
module flowctl_decode
    import flowctl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] instr_i,
    input  logic              wide_page_i,
    output xfer_e             kind_o,
    output logic              two_byte_o
);

    // Purpose: detect the two-byte instructions by their upper seven bits.
    always_comb begin
        two_byte_o = (instr_i[BYTE_W-1:1] == OPC_JMP_HI[7:1]) ||
                     (instr_i[BYTE_W-1:1] == OPC_JSR_HI[7:1]);
    end

    // Purpose: map the byte and page class to a transfer kind.
    always_comb begin
        kind_o = XFER_SEQ;
        if (instr_i[BYTE_W-1:1] == OPC_JMP_HI[7:1]) begin
            kind_o = XFER_JMP;
        end else if (instr_i[BYTE_W-1:1] == OPC_JSR_HI[7:1]) begin
            kind_o = XFER_JSR;
        end else if (instr_i == OPC_RET) begin
            kind_o = XFER_RET;
        end else if (instr_i == OPC_RETSK) begin
            kind_o = XFER_RETSK;
        end else if (instr_i == OPC_JID) begin
            kind_o = XFER_JID;
        end else if (instr_i[BYTE_W-1]) begin
            if (wide_page_i) begin
                kind_o = XFER_JP;
            end else if (instr_i[BYTE_W-2]) begin
                kind_o = XFER_JP;
            end else if (instr_i != OPC_LQ_IND) begin
                kind_o = XFER_JSRP;
            end
        end
    end

endmodule

// File: rtl/flowctl_target.sv
// Forms the sequential address and the transfer target for one step.
// Assumes PC_W = BYTE_W + 1 and PC_W = 2*DIGIT_W + 1; the ROM word
// arrives combinationally for the indirect jump.
module flowctl_target
    import flowctl_pkg::*;
#(
    parameter int PC_W     = 9,
    parameter int PAGE_W   = 6,
    parameter int BYTE_W   = 8,
    parameter int DIGIT_W  = 4,
    parameter int SUB_PAGE = 2
) (
    input  logic [PC_W-1:0]    pc_i,
    input  xfer_e              kind_i,
    input  logic               two_byte_i,
    input  logic               wide_page_i,
    input  logic [PAGE_W:0]    offset_i,
    input  logic               hi_bit_i,
    input  logic [BYTE_W-1:0]  ext_i,
    input  logic [DIGIT_W-1:0] acc_i,
    input  logic [DIGIT_W-1:0] ram_i,
    input  logic [BYTE_W-1:0]  rom_data_i,
    input  logic [PC_W-1:0]    stack_top_i,
    output logic [PC_W-1:0]    seq_pc_o,
    output logic [PC_W-1:0]    next_pc_o,
    output logic [PC_W-1:0]    rom_addr_o
);

    localparam int SEL_W  = PC_W - PAGE_W;
    localparam int HIGH_W = PC_W - 2 * DIGIT_W;
    localparam logic [SEL_W-1:0] SUB_SEL = SEL_W'(SUB_PAGE);

    logic [PC_W-1:0] jp_target;

    // Purpose: address after the current instruction, counting its length.
    always_comb begin
        seq_pc_o = pc_i + (two_byte_i ? PC_W'(2) : PC_W'(1));
    end

    // Purpose: indirect lookup address from the high pc bit and two digits.
    always_comb begin
        rom_addr_o = {pc_i[PC_W-1 -: HIGH_W], acc_i, ram_i};
    end

    // Purpose: page-relative target, 7-bit offset on wide pages else 6-bit.
    always_comb begin
        if (wide_page_i) begin
            jp_target = {pc_i[PC_W-1:PAGE_W+1], offset_i[PAGE_W:0]};
        end else begin
            jp_target = {pc_i[PC_W-1:PAGE_W], offset_i[PAGE_W-1:0]};
        end
    end

    // Purpose: select the address loaded into the counter this step.
    always_comb begin
        case (kind_i)
            XFER_JMP, XFER_JSR:   next_pc_o = {hi_bit_i, ext_i};
            XFER_JSRP:            next_pc_o = {SUB_SEL, offset_i[PAGE_W-1:0]};
            XFER_JP:              next_pc_o = jp_target;
            XFER_RET, XFER_RETSK: next_pc_o = stack_top_i;
            XFER_JID:             next_pc_o = {pc_i[PC_W-1], rom_data_i};
            default:              next_pc_o = seq_pc_o;
        endcase
    end

endmodule

// File: rtl/flowctl_stack.sv
// Fixed-depth return stack built as a shift register. A push shifts
// every entry down and loads the top; a pop shifts up and the bottom
// entry keeps its value. Push and pop are never requested together.
module flowctl_stack #(
    parameter int PC_W  = 9,
    parameter int DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] push_val_i,
    output logic [PC_W-1:0] top_o
);

    logic [PC_W-1:0] ent [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_ent
            // Purpose: update one stack entry on reset, push or pop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[gi] <= '0;
                end else if (push_i) begin
                    if (gi == 0) ent[gi] <= push_val_i;
                    else         ent[gi] <= ent[(gi == 0) ? 0 : gi - 1];
                end else if (pop_i) begin
                    if (gi == DEPTH - 1) ent[gi] <= ent[gi];
                    else                 ent[gi] <= ent[(gi == DEPTH - 1) ? gi : gi + 1];
                end
            end
        end
    endgenerate

    assign top_o = ent[0];

    assert_push_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> ent[0] == $past(push_val_i));

    generate
        if (DEPTH > 1) begin : g_chk
            assert_push_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
                push_i |=> ent[1] == $past(ent[0]));
            assert_pop_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
                pop_i |=> ent[0] == $past(ent[1]));
            assert_pop_bottom_R11: assert property (@(posedge clk) disable iff (!rst_n)
                pop_i |=> $stable(ent[DEPTH-1]));
        end
    endgenerate

    assert_one_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/flowctl_unit.sv
// Control-transfer unit: program counter, skip flag and return stack.
// Executes one instruction per step pulse; the second byte of a long
// jump or call arrives together with the first on instr_ext.
module flowctl_unit
    import flowctl_pkg::*;
#(
    parameter int PC_W        = 9,
    parameter int PAGE_W      = 6,
    parameter int BYTE_W      = 8,
    parameter int DIGIT_W     = 4,
    parameter int STACK_DEPTH = 2,
    parameter int SUB_PAGE    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [BYTE_W-1:0]  instr,
    input  logic [BYTE_W-1:0]  instr_ext,
    input  logic [DIGIT_W-1:0] acc,
    input  logic [DIGIT_W-1:0] ram_val,
    input  logic [BYTE_W-1:0]  rom_data,
    output logic [PC_W-1:0]    fetch_addr,
    output logic               skip_pending,
    output logic [PC_W-1:0]    rom_addr
);

    localparam int WIDE_W = PC_W - PAGE_W - 1;

    logic [PC_W-1:0] pc_q;
    logic            skip_q;
    logic            wide_page;
    xfer_e           kind;
    logic            two_byte;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] next_pc;
    logic [PC_W-1:0] stack_top;
    logic            live;
    logic            do_push;
    logic            do_pop;

    // Purpose: pages 2 and 3 share the upper page bits 01.
    assign wide_page = (pc_q[PC_W-1:PAGE_W+1] == WIDE_W'(1));

    flowctl_decode #(.BYTE_W(BYTE_W)) u_dec (
        .instr_i     (instr),
        .wide_page_i (wide_page),
        .kind_o      (kind),
        .two_byte_o  (two_byte)
    );

    flowctl_target #(
        .PC_W(PC_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W),
        .DIGIT_W(DIGIT_W), .SUB_PAGE(SUB_PAGE)
    ) u_tgt (
        .pc_i        (pc_q),
        .kind_i      (kind),
        .two_byte_i  (two_byte),
        .wide_page_i (wide_page),
        .offset_i    (instr[PAGE_W:0]),
        .hi_bit_i    (instr[0]),
        .ext_i       (instr_ext),
        .acc_i       (acc),
        .ram_i       (ram_val),
        .rom_data_i  (rom_data),
        .stack_top_i (stack_top),
        .seq_pc_o    (seq_pc),
        .next_pc_o   (next_pc),
        .rom_addr_o  (rom_addr)
    );

    // Purpose: an instruction executes only when stepped and not skipped.
    assign live    = step && !skip_q;
    assign do_push = live && (kind == XFER_JSR || kind == XFER_JSRP);
    assign do_pop  = live && (kind == XFER_RET || kind == XFER_RETSK);

    flowctl_stack #(.PC_W(PC_W), .DEPTH(STACK_DEPTH)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (do_push),
        .pop_i      (do_pop),
        .push_val_i (seq_pc),
        .top_o      (stack_top)
    );

    // Purpose: advance or load the counter and track the pending skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            skip_q <= 1'b0;
        end else if (step) begin
            if (skip_q) begin
                pc_q   <= seq_pc;
                skip_q <= 1'b0;
            end else begin
                pc_q   <= next_pc;
                skip_q <= (kind == XFER_RETSK);
            end
        end
    end

    assign fetch_addr   = pc_q;
    assign skip_pending = skip_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc_q) && $stable(skip_q));

    assert_skip_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && skip_q) |=> !skip_q);

    assert_skip_no_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && skip_q) |-> !do_push && !do_pop);

    assert_ret_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && kind == XFER_RET) |=> pc_q == $past(stack_top));

    assert_subpage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && kind == XFER_JSRP) |=> pc_q[PC_W-1:PAGE_W] == (PC_W-PAGE_W)'(SUB_PAGE));

    assert_jp_keeps_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && kind == XFER_JP) |=> pc_q[PC_W-1:PAGE_W+1] == $past(pc_q[PC_W-1:PAGE_W+1]));

    assert_jid_keeps_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live && kind == XFER_JID) |=> pc_q[PC_W-1] == $past(pc_q[PC_W-1]));

endmodule

// File: tb/flowctl_unit_test.sv
`timescale 1ns/1ps
module flowctl_unit_test;

    typedef struct {
        logic [8:0] pc;
        logic       skp;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic [7:0] instr = 8'h00;
    logic [7:0] instr_ext = 8'h00;
    logic [3:0] acc = 4'h0;
    logic [3:0] ram_val = 4'h0;
    logic [7:0] rom_data = 8'h00;
    logic [8:0] fetch_addr;
    logic       skip_pending;
    logic [8:0] rom_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t q[$];
    logic stepped = 1'b0;

    logic [8:0] m_pc, m_sa, m_sb;
    logic       m_skip;

    always #2.5 clk = ~clk;

    flowctl_unit uut (
        .clk(clk), .rst_n(rst_n), .step(step), .instr(instr),
        .instr_ext(instr_ext), .acc(acc), .ram_val(ram_val),
        .rom_data(rom_data), .fetch_addr(fetch_addr),
        .skip_pending(skip_pending), .rom_addr(rom_addr)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, act, expv);
        end
    endtask

    // Reference model written from the requirements.
    task automatic exec(input logic [7:0] b, input logic [7:0] b2,
                        input logic [3:0] a, input logic [3:0] r,
                        input logic [7:0] rd, input string tag);
        logic       two;
        logic       wide;
        logic [8:0] seqa;
        exp_t       e;
        two  = (b[7:1] == 7'h30) || (b[7:1] == 7'h34);
        wide = (m_pc[8:7] == 2'b01);
        seqa = m_pc + (two ? 9'd2 : 9'd1);
        @(negedge clk);
        instr = b; instr_ext = b2; acc = a; ram_val = r; rom_data = rd; step = 1'b1;
        if (m_skip) begin
            m_pc = seqa; m_skip = 1'b0;
        end else if (b[7:1] == 7'h30) begin
            m_pc = {b[0], b2};
        end else if (b[7:1] == 7'h34) begin
            m_sb = m_sa; m_sa = seqa; m_pc = {b[0], b2};
        end else if (b == 8'h48 || b == 8'h49) begin
            m_pc = m_sa; m_sa = m_sb; m_skip = (b == 8'h49);
        end else if (b == 8'hFF) begin
            #1 check({tag, " R10 rom_addr"}, rom_addr, {m_pc[8], a, r});
            m_pc = {m_pc[8], rd};
        end else if (b[7] && wide) begin
            m_pc = {m_pc[8:7], b[6:0]};
        end else if (b[7:6] == 2'b11) begin
            m_pc = {m_pc[8:6], b[5:0]};
        end else if (b[7:6] == 2'b10 && b != 8'hBF) begin
            m_sb = m_sa; m_sa = seqa; m_pc = {3'b010, b[5:0]};
        end else begin
            m_pc = seqa;
        end
        e.pc = m_pc; e.skp = m_skip; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        step = 1'b0;
    endtask

    // Monitor: note each executed step, then compare at the next falling edge.
    always @(posedge clk) stepped <= step && rst_n;

    always @(negedge clk) begin
        if (stepped) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard underflow: actual step expected none");
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " pc"}, fetch_addr, e.pc);
                check({e.tag, " skip"}, {8'd0, skip_pending}, {8'd0, e.skp});
            end
        end
    end

    initial begin
        m_pc = 9'd0; m_sa = 9'd0; m_sb = 9'd0; m_skip = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", fetch_addr, 9'd0);
        check("R1 reset skip", {8'd0, skip_pending}, 9'd0);
        rst_n = 1'b1;
        exec(8'h48, 8'h00, 0, 0, 0, "R1 ret after reset");
        exec(8'h00, 8'h00, 0, 0, 0, "R2 seq");
        exec(8'h3C, 8'h00, 0, 0, 0, "R2 seq");
        repeat (4) @(negedge clk);
        check("R2 idle hold", fetch_addr, 9'd2);
        exec(8'h61, 8'h23, 0, 0, 0, "R3 long jump");
        exec(8'hC5, 8'h00, 0, 0, 0, "R7 page jump narrow");
        exec(8'hBF, 8'h00, 0, 0, 0, "R7 0xBF sequential");
        exec(8'h69, 8'h80, 0, 0, 0, "R4 long call");
        exec(8'h8A, 8'h00, 0, 0, 0, "R5 page call");
        exec(8'h95, 8'h00, 0, 0, 0, "R6 wide jump page2");
        exec(8'hF0, 8'h00, 0, 0, 0, "R6 wide jump 0xF0");
        exec(8'hA1, 8'h00, 0, 0, 0, "R6 page3 not a call");
        exec(8'h48, 8'h00, 0, 0, 0, "R8 return");
        exec(8'h48, 8'h00, 0, 0, 0, "R8 return second");
        exec(8'h48, 8'h00, 0, 0, 0, "R11 bottom duplicated");
        exec(8'h68, 8'h10, 0, 0, 0, "R4 push one");
        exec(8'h68, 8'h20, 0, 0, 0, "R4 push two");
        exec(8'h81, 8'h00, 0, 0, 0, "R11 third push");
        exec(8'h48, 8'h00, 0, 0, 0, "R11 pop newest");
        exec(8'h48, 8'h00, 0, 0, 0, "R11 pop second");
        exec(8'h48, 8'h00, 0, 0, 0, "R11 oldest lost");
        exec(8'h85, 8'h00, 0, 0, 0, "R5 call again");
        exec(8'h49, 8'h00, 0, 0, 0, "R9 return and skip");
        exec(8'h60, 8'h55, 0, 0, 0, "R9 skipped two-byte");
        exec(8'h48, 8'h00, 0, 0, 0, "R9 stack untouched");
        exec(8'h49, 8'h00, 0, 0, 0, "R9 skip again");
        exec(8'h48, 8'h00, 0, 0, 0, "R9 skipped return");
        exec(8'h48, 8'h00, 0, 0, 0, "R9 no pop in skip");
        exec(8'h61, 8'h40, 0, 0, 0, "R3 jump high");
        exec(8'hFF, 8'h00, 4'hA, 4'h5, 8'h37, "R10 indirect high");
        exec(8'h60, 8'h10, 0, 0, 0, "R3 jump low");
        exec(8'hFF, 8'h00, 4'h3, 4'hC, 8'hFE, "R10 indirect low");
        exec(8'h61, 8'hFF, 0, 0, 0, "R3 jump top");
        exec(8'h00, 8'h00, 0, 0, 0, "R2 wrap");
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset again", fetch_addr, 9'd0);
        rst_n = 1'b1;
        m_pc = 9'd0; m_sa = 9'd0; m_sb = 9'd0; m_skip = 1'b0;
        exec(8'h48, 8'h00, 0, 0, 0, "R1 stack cleared");
        repeat (2) @(negedge clk);
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d left expected 0", q.size());
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule